// File: doc/BRIEF.md
# ADC Sample Window Comparator

This block sits beside an ADC and inspects every conversion result as it arrives. Each result that comes with a one-cycle valid strobe is compared with two programmable 16-bit limits: an "above" limit and a "below" limit. When the sample meets the window condition, a sticky hit flag is set. Software can poll this flag, or it can reach the CPU as an interrupt when the interrupt enable is set. No software action is needed for each sample.

There is no mode bit. The order of the two limits alone decides whether the flag marks samples inside the window or outside it. When the below limit is greater than the above limit, the condition is a sample strictly between them. Otherwise, the condition is a sample strictly greater than the above limit or strictly less than the below limit. Software writes each limit one byte at a time through a small byte-wide register port. Every write takes effect on the clock edge where it happens.

Top module: `adc_window_watch`

## Requirements
- R1: After a synchronous reset, the above limit is 0xFFFF, the below limit is 0x0000, and the hit flag, the interrupt enable and `win_irq` are all 0.
- R2: Register addresses are: 0 for the above limit low byte, 1 for the above limit high byte, 2 for the below limit low byte, 3 for the below limit high byte, and 4 for control. In the control register, bit 0 is the hit flag and bit 1 is the interrupt enable. `rd_data` shows the register at `reg_addr` one clock after the address is presented, using the values from before any write on that same edge. Addresses 5 to 7 read as 0, and writes to them change nothing.
- R3: When the below limit is greater than the above limit, a strobed sample sets the flag only if it is strictly greater than the above limit and strictly less than the below limit.
- R4: When the below limit is less than or equal to the above limit, a strobed sample sets the flag if it is strictly greater than the above limit or strictly less than the below limit.
- R5: A sample is compared only when `smp_valid` is 1. The flag rises on the clock edge that captures the strobe.
- R6: With the reset limits, no 16-bit sample sets the flag.
- R7: Once set, the flag stays set until a control write has bit 0 equal to 0. A control write with bit 0 equal to 1 neither sets nor clears the flag.
- R8: If a hit occurs on the same edge as a clearing control write, the flag ends up set.
- R9: `win_irq` equals the flag AND the interrupt enable, and it is registered so that it changes on the same edge as the flag.
- R10: Each byte write takes effect at once. The compare uses the current 16-bit limit made from both bytes, even while only one byte has been rewritten.
- R11: Reading any register has no side effect on the flag, the enable or the limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe marking a new ADC sample |
| smp_data | input | 16 | ADC sample value |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| rd_data | output | 8 | Registered read data for `reg_addr` |
| win_flag | output | 1 | Sticky hit flag |
| win_irq | output | 1 | Interrupt request (flag AND enable) |

## Verification
Samples are placed exactly on each limit, one step inside it and one step outside it, under both limit orders and with the two limits equal. These cases tell a strict compare from an inclusive one, and the inside rule from the outside rule. The reset limits are tried with 0x0000, 0x8000 and 0xFFFF, which shows that no value can hit. A hit-level sample without its strobe, a control write with bit 0 set, and a clear on the same edge as a hit show which source controls the flag. A single high-byte rewrite that flips the limit order shows that the compare uses the half-updated 16-bit limit.

// File: rtl/adcw_pkg.sv
package adcw_pkg;
  localparam int CTRL_FLAG_BIT = 0;
  localparam int CTRL_EN_BIT   = 1;

  typedef enum logic {
    MODE_OUTSIDE = 1'b0,
    MODE_INSIDE  = 1'b1
  } win_mode_e;
endpackage

// File: rtl/adcw_limit_reg.sv
module adcw_limit_reg #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3,
  parameter int BASE   = 0,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [DATA_W-1:0] lim
);
  localparam int NB = DATA_W / BYTE_W;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        byte_q <= RESET_VAL[b*BYTE_W +: BYTE_W];
      end else if (we && addr == ADDR_W'(BASE + b)) begin
        byte_q <= wdata;
      end
    end
    assign lim[b*BYTE_W +: BYTE_W] = byte_q;
  end

  // R1: reset loads the limit's reset value
  p_reset_value_r1: assert property (@(posedge clk) rst |=> (lim == RESET_VAL));
  // R2: no write in this limit's range leaves it unchanged
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(we && int'(addr) >= BASE && int'(addr) < BASE + NB) |=> $stable(lim));
endmodule

// File: rtl/adcw_compare.sv
module adcw_compare
  import adcw_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] above_lim,
  input  logic [DATA_W-1:0] below_lim,
  input  logic [DATA_W-1:0] sample,
  output logic              hit
);
  win_mode_e mode;
  logic      gt_above;
  logic      lt_below;

  always_comb begin
    mode     = (below_lim > above_lim) ? MODE_INSIDE : MODE_OUTSIDE;
    gt_above = sample > above_lim;
    lt_below = sample < below_lim;
    case (mode)
      MODE_INSIDE: hit = gt_above && lt_below;
      default:     hit = gt_above || lt_below;
    endcase
  end
endmodule

// File: rtl/adcw_flag_ctrl.sv
module adcw_flag_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic smp_valid,
  input  logic hit,
  input  logic ctrl_we,
  input  logic wr_flag,
  input  logic wr_en,
  output logic flag_q,
  output logic en_q,
  output logic irq_q
);
  logic flag_d;
  logic en_d;

  always_comb begin
    flag_d = flag_q;
    en_d   = en_q;
    if (ctrl_we) begin
      en_d = wr_en;
      if (!wr_flag) flag_d = 1'b0;
    end
    if (smp_valid && hit) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      en_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      en_q   <= en_d;
      irq_q  <= flag_d && en_d;
    end
  end

  // R5 R8: a strobed hit always leaves the flag set
  p_hit_sets_r8: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && hit) |=> flag_q);
  // R5: without a strobed hit the flag cannot rise
  p_no_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !(smp_valid && hit)) |=> !flag_q);
  // R7: only a clearing control write drops the flag
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(ctrl_we && !wr_flag)) |=> flag_q);
  // R9: the interrupt tracks flag and enable
  p_irq_r9: assert property (@(posedge clk) disable iff (rst)
    irq_q == (flag_q && en_q));
endmodule

// File: rtl/adc_window_watch.sv
module adc_window_watch
  import adcw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] rd_data,
  output logic              win_flag,
  output logic              win_irq
);
  localparam int NB         = DATA_W / BYTE_W;
  localparam int ABOVE_BASE = 0;
  localparam int BELOW_BASE = NB;
  localparam int CTRL_ADDR  = 2 * NB;

  logic [DATA_W-1:0] above_lim;
  logic [DATA_W-1:0] below_lim;
  logic              hit;
  logic              ctrl_we;
  logic              flag_q;
  logic              en_q;
  logic              irq_q;
  logic [BYTE_W-1:0] rd_d;
  logic [BYTE_W-1:0] rd_q;

  adcw_limit_reg #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W),
    .BASE(ABOVE_BASE), .RESET_VAL({DATA_W{1'b1}})
  ) u_above (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .lim(above_lim)
  );

  adcw_limit_reg #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W),
    .BASE(BELOW_BASE), .RESET_VAL({DATA_W{1'b0}})
  ) u_below (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .lim(below_lim)
  );

  adcw_compare #(.DATA_W(DATA_W)) u_cmp (
    .above_lim(above_lim), .below_lim(below_lim),
    .sample(smp_data), .hit(hit)
  );

  assign ctrl_we = reg_we && (reg_addr == ADDR_W'(CTRL_ADDR));

  adcw_flag_ctrl u_flag (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .hit(hit),
    .ctrl_we(ctrl_we),
    .wr_flag(reg_wdata[CTRL_FLAG_BIT]), .wr_en(reg_wdata[CTRL_EN_BIT]),
    .flag_q(flag_q), .en_q(en_q), .irq_q(irq_q)
  );

  always_comb begin
    rd_d = '0;
    for (int b = 0; b < NB; b++) begin
      if (reg_addr == ADDR_W'(ABOVE_BASE + b)) rd_d = above_lim[b*BYTE_W +: BYTE_W];
      if (reg_addr == ADDR_W'(BELOW_BASE + b)) rd_d = below_lim[b*BYTE_W +: BYTE_W];
    end
    if (reg_addr == ADDR_W'(CTRL_ADDR)) begin
      rd_d[CTRL_FLAG_BIT] = flag_q;
      rd_d[CTRL_EN_BIT]   = en_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_d;
  end

  assign rd_data  = rd_q;
  assign win_flag = flag_q;
  assign win_irq  = irq_q;

  // R6: the reset limits admit no sample
  p_reset_limits_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (above_lim == {DATA_W{1'b1}} && below_lim == {DATA_W{1'b0}}) |-> !hit);
  // R11: a cycle with no write and no hit keeps flag and enable
  p_read_no_effect_r11: assert property (@(posedge clk) disable iff (rst)
    (!reg_we && !(smp_valid && hit)) |=> ($stable(flag_q) && $stable(en_q)));
endmodule

// File: tb/test_adc_window_watch.sv
module test_adc_window_watch;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  rd_data;
  logic        win_flag;
  logic        win_irq;

  always #2 clk = ~clk;

  adc_window_watch i_adc_window_watch (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .rd_data(rd_data), .win_flag(win_flag), .win_irq(win_irq)
  );

  typedef struct {
    int          due;
    logic        flag;
    logic        irq;
    logic [7:0]  rd;
    string       tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int failures = 0;

  // reference model state
  logic [15:0] m_above = 16'hFFFF;
  logic [15:0] m_below = 16'h0000;
  logic        m_flag = 1'b0;
  logic        m_en = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected items when due
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "win_flag", int'(win_flag), int'(e.flag));
      chk(e.tag, "win_irq", int'(win_irq), int'(e.irq));
      chk(e.tag, "rd_data", int'(rd_data), int'(e.rd));
    end
  end

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_above[7:0];
      3'd1: return m_above[15:8];
      3'd2: return m_below[7:0];
      3'd3: return m_below[15:8];
      3'd4: return {6'b0, m_en, m_flag};
      default: return 8'h00;
    endcase
  endfunction

  // driver: one cycle of stimulus, pushes the expected post-edge outputs
  task automatic step(input logic we, input logic [2:0] a, input logic [7:0] wd,
                      input logic sv, input logic [15:0] d, input string tag);
    exp_t e;
    logic hit;
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = wd; smp_valid = sv; smp_data = d;
    e.rd = m_read(a);
    if (m_below > m_above) hit = sv && (d > m_above) && (d < m_below);
    else                   hit = sv && ((d > m_above) || (d < m_below));
    if (we) begin
      case (a)
        3'd0: m_above[7:0]  = wd;
        3'd1: m_above[15:8] = wd;
        3'd2: m_below[7:0]  = wd;
        3'd3: m_below[15:8] = wd;
        3'd4: begin m_en = wd[1]; if (!wd[0]) m_flag = 1'b0; end
        default: ;
      endcase
    end
    if (hit) m_flag = 1'b1;
    e.due = cyc + 1; e.flag = m_flag; e.irq = m_flag && m_en; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] wd, input string tag);
    step(1'b1, a, wd, 1'b0, 16'h0, tag);
  endtask
  task automatic samp(input logic [15:0] d, input string tag);
    step(1'b0, 3'd4, 8'h0, 1'b1, d, tag);
  endtask
  task automatic rd(input logic [2:0] a, input string tag);
    step(1'b0, a, 8'h0, 1'b0, 16'h0, tag);
  endtask
  task automatic limits(input logic [15:0] ab, input logic [15:0] be, input string tag);
    wr(3'd0, ab[7:0], tag); wr(3'd1, ab[15:8], tag);
    wr(3'd2, be[7:0], tag); wr(3'd3, be[15:8], tag);
    wr(3'd4, 8'h00, tag);
  endtask
  task automatic probe(input logic [15:0] d, input string tag);
    samp(d, tag); rd(3'd4, tag); wr(3'd4, {6'b0, m_en, 1'b0}, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R1", "win_flag after reset", int'(win_flag), 0);
    chk("R1", "win_irq after reset", int'(win_irq), 0);
    // R1 R2: reset values through the read port, unused addresses read 0
    for (int a = 0; a < 8; a++) rd(3'(a), "R1");
    // R2: writes to unused addresses do nothing
    wr(3'd5, 8'hA5, "R2"); wr(3'd7, 8'h5A, "R2");
    for (int a = 0; a < 8; a++) rd(3'(a), "R2");
    // R6: reset limits never hit
    probe(16'h0000, "R6"); probe(16'h8000, "R6"); probe(16'hFFFF, "R6");
    // R3: inside window, strict edges
    limits(16'h1000, 16'h2000, "R3");
    probe(16'h1000, "R3"); probe(16'h1001, "R3"); probe(16'h1FFF, "R3");
    probe(16'h2000, "R3"); probe(16'h0500, "R3"); probe(16'hF000, "R3");
    // R4: outside window
    limits(16'h3000, 16'h1000, "R4");
    probe(16'h2000, "R4"); probe(16'h0FFF, "R4"); probe(16'h3001, "R4");
    probe(16'h1000, "R4"); probe(16'h3000, "R4");
    // R4: equal limits
    limits(16'h5000, 16'h5000, "R4");
    probe(16'h5000, "R4"); probe(16'h5001, "R4"); probe(16'h4FFF, "R4");
    // R5: hit-level data without strobe
    step(1'b0, 3'd4, 8'h0, 1'b0, 16'h9000, "R5"); rd(3'd4, "R5");
    // R7: sticky; bit0=1 write keeps it, reads keep it
    samp(16'h9000, "R7"); rd(3'd0, "R11"); rd(3'd4, "R11"); rd(3'd4, "R11");
    wr(3'd4, 8'h01, "R7"); rd(3'd4, "R7");
    wr(3'd4, 8'h00, "R7"); rd(3'd4, "R7");
    wr(3'd4, 8'h01, "R7"); rd(3'd4, "R7");
    // R8: hit and clear on the same edge
    samp(16'h9000, "R8");
    step(1'b1, 3'd4, 8'h00, 1'b1, 16'h9100, "R8"); rd(3'd4, "R8");
    // R9: interrupt enable
    wr(3'd4, 8'h02, "R9"); rd(3'd4, "R9");
    samp(16'h9000, "R9"); rd(3'd4, "R9");
    wr(3'd4, 8'h03, "R9"); wr(3'd4, 8'h01, "R9"); wr(3'd4, 8'h02, "R9");
    wr(3'd4, 8'h00, "R9");
    // R10: partial update flips order to outside mode
    limits(16'h0100, 16'h0200, "R10");
    probe(16'h0050, "R10");
    wr(3'd1, 8'h03, "R10");
    probe(16'h0050, "R10"); probe(16'h0250, "R10");
    for (int a = 0; a < 5; a++) rd(3'(a), "R10");
    repeat (3) rd(3'd6, "R2");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule